// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, latches each one on its rising edge and filters them through a mask register. It picks the most urgent request that is still allowed to run and raises one interrupt line toward a processor. When the processor pulses the acknowledge input for one cycle, the block presents an 8-bit vector in that same cycle. It also marks the winning input as in service, so lower-priority requests stay blocked until software ends that interrupt.

Software reaches the block through a register port with two addresses. A write to address 0 carries a command byte. A write to address 1 carries either one word of the configuration sequence or a new mask. One command byte starts the configuration sequence, which then takes three data-port words in a fixed order: the vector base, the cascade word and the mode word. Other command bytes end the service of a single input, or choose whether address-0 reads show pending requests or in-service inputs. The cascade word has no effect inside the block. It is stored and made visible at an output, so that a paired device, or the logic around it, can use it.

Priority is fixed: input 0 is the highest and input 7 the lowest. If the processor acknowledges when no request can be serviced, for example because the request line fell in the meantime, the block answers with the vector for input 7. In that case it records nothing as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers are 0, int_out is 0, address-0 reads return the request register, and vector base, cascade word and auto-EOI are 0.
- R2: A command write of 0x11 clears the mask and in-service registers and sets address-0 reads back to the request register. The next three data writes then load, in order, the vector base, the cascade word and the mode word. Only after the third of them do data writes load the mask again.
- R3: casc_cfg always shows the cascade word from the most recent configuration sequence, exactly as it was written.
- R4: Outside the configuration sequence, a data write loads the mask register. A mask bit of 1 masks its input. An address-1 read returns the mask register at all times.
- R5: A request bit is set in the cycle after its input rises from 0 to 1. It is cleared when the input is seen low, or when the request is acknowledged. An input that stays high does not request again.
- R6: Priority is fixed, with input 0 highest. int_out is 1 exactly when the lowest-numbered unmasked pending request has no in-service bit at its own index or at any lower index.
- R7: An acknowledge while int_out is 1 drives vec_out = base + n for the winning input n, clears request bit n, and, when auto-EOI is off, sets in-service bit n. vec_out is 0 in cycles without an acknowledge.
- R8: Bit 1 of the mode word turns on auto-EOI. With auto-EOI on, an acknowledge never sets an in-service bit.
- R9: A command write of 0x60+n (n = 0..7) clears in-service bit n and leaves every other bit unchanged.
- R10: After a command write of 0x0B, address-0 reads return the in-service register. After a command write of 0x0A, they return the request register.
- R11: An acknowledge while int_out is 0 drives vec_out = base + 7 and leaves the in-service register unchanged. This holds even when input 7 is masked.
- R12: A masked input still sets its request bit, but it cannot raise int_out or win an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register address: 0 = command/status, 1 = data/mask |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current addr |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector, valid while inta is high |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
The bench builds the block with its default command codes and the auto-EOI flag at mode bit 1. This lets it use the exact byte values 0x11, 0x0A, 0x0B and 0x60+n, and the base, cascade and mode words that a master/slave pair would be given. The bench runs both a normal-EOI configuration and an auto-EOI reconfiguration. Because of that, the nesting of in-service bits, the spurious input-7 reply with input 7 masked, and requests that vanish before acknowledge all come up. The bench then adds a long pseudo-random stretch of toggling inputs, acknowledges, EOIs and mask writes, and checks each cycle against a behavioural model.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [7:0] INIT_WORD = 8'h11,
  parameter logic [7:0] SEL_IRR   = 8'h0A,
  parameter logic [7:0] SEL_ISR   = 8'h0B,
  parameter logic [4:0] EOI_OP    = 5'b01100,
  parameter int         AEOI_BIT  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic [7:0] vec_out,
  output logic [7:0] casc_cfg
);
  localparam int NIRQ = 8;
  localparam int IW   = $clog2(NIRQ);

  typedef enum logic [1:0] {RUN, GET_BASE, GET_CASC, GET_MODE} st_t;

  st_t        st;
  logic [7:0] irr, isr, imr, irq_q, base;
  logic       aeoi, rsel_isr;

  logic          svc_any;
  logic [IW-1:0] svc_idx;

  wire cmd_wr   = wr_en && !addr;
  wire dat_wr   = wr_en &&  addr;
  wire init_cmd = cmd_wr && wdata == INIT_WORD;
  wire eoi_cmd  = cmd_wr && wdata[7:3] == EOI_OP;
  wire ack_hit  = inta && svc_any;

  wire [7:0] req     = irr & ~imr;
  wire [7:0] ack_bit = ack_hit ? 8'(1) << svc_idx : '0;
  wire [7:0] eoi_bit = eoi_cmd ? 8'(1) << wdata[2:0] : '0;

  always_comb begin
    logic done;
    done    = 1'b0;
    svc_any = 1'b0;
    svc_idx = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (!done) begin
        if (isr[i]) begin
          done = 1'b1;
        end else if (req[i]) begin
          done    = 1'b1;
          svc_any = 1'b1;
          svc_idx = IW'(i);
        end
      end
    end
  end

  assign int_out  = svc_any;
  assign vec_out  = !inta ? '0 : base + (svc_any ? 8'(svc_idx) : 8'(NIRQ - 1));
  assign rdata    = addr ? imr : (rsel_isr ? isr : irr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq_in;
      irr   <= (irr | (irq_in & ~irq_q)) & irq_in & ~ack_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      isr <= '0;
    else if (init_cmd)
      isr <= '0;
    else
      isr <= (isr & ~eoi_bit) | (aeoi ? '0 : ack_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RUN;
      imr      <= '1;
      base     <= '0;
      casc_cfg <= '0;
      aeoi     <= 1'b0;
      rsel_isr <= 1'b0;
    end else if (init_cmd) begin
      st       <= GET_BASE;
      imr      <= '0;
      rsel_isr <= 1'b0;
    end else begin
      if (cmd_wr && wdata == SEL_ISR) rsel_isr <= 1'b1;
      if (cmd_wr && wdata == SEL_IRR) rsel_isr <= 1'b0;
      if (dat_wr) begin
        unique case (st)
          GET_BASE: begin base <= wdata; st <= GET_CASC; end
          GET_CASC: begin casc_cfg <= wdata; st <= GET_MODE; end
          GET_MODE: begin aeoi <= wdata[AEOI_BIT]; st <= RUN; end
          default:  imr <= wdata;
        endcase
      end
    end
  end

  a_r6_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(irr & ~imr)));

  a_r5_req_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irq_in)) == '0));

  a_r7_ack_marks_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi && !cmd_wr) |=> isr[$past(svc_idx)]);

  a_r7_one_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr & ~$past(isr)) <= 1));

  a_r8_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi && !cmd_wr) |=> $stable(isr));

  a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !inta) |=> !isr[$past(wdata[2:0])]);

  a_r11_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !cmd_wr) |=> $stable(isr));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, casc_cfg;
  logic       int_out;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_out(vec_out), .casc_cfg(casc_cfg));

  always #10 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 8'hFF, m_prev = 0, m_base = 0, m_casc = 0;
  bit         m_aeoi = 0, m_rsel = 0;
  int         m_phase = 0;

  function automatic int winner();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_irr[i] && !m_imr[i]) return i;
    end
    return -1;
  endfunction

  task automatic step(input bit a, input bit we, input logic [7:0] wd,
                      input bit ack, input logic [7:0] irq);
    int w;
    logic [7:0] e_rd, e_vec, ackm;
    bit e_int;
    addr = a; wr_en = we; wdata = wd; inta = ack; irq_in = irq;
    #5;
    w     = winner();
    e_int = (w >= 0);
    e_rd  = a ? m_imr : (m_rsel ? m_isr : m_irr);
    e_vec = !ack ? 8'h00 : (w >= 0 ? m_base + 8'(w) : m_base + 8'd7);
    n_vec++;
    if (int_out !== e_int || rdata !== e_rd || vec_out !== e_vec || casc_cfg !== m_casc) begin
      n_bad++;
      $display("FAIL %s t=%0t int=%b/%b rd=%h/%h vec=%h/%h casc=%h/%h (actual/expected)",
               cur_req, $time, int_out, e_int, rdata, e_rd, vec_out, e_vec, casc_cfg, m_casc);
    end
    @(posedge clk);
    ackm   = (ack && w >= 0) ? (8'd1 << w) : 8'd0;
    m_irr  = (m_irr | (irq & ~m_prev)) & irq & ~ackm;
    m_prev = irq;
    if (!a && we && wd == 8'h11) begin
      m_isr = 0; m_imr = 0; m_rsel = 0; m_phase = 1;
    end else begin
      if (!a && we && wd[7:3] == 5'b01100) m_isr = m_isr & ~(8'd1 << wd[2:0]);
      if (!m_aeoi) m_isr = m_isr | ackm;
      if (!a && we && wd == 8'h0B) m_rsel = 1;
      if (!a && we && wd == 8'h0A) m_rsel = 0;
      if (a && we) begin
        case (m_phase)
          1: begin m_base = wd; m_phase = 2; end
          2: begin m_casc = wd; m_phase = 3; end
          3: begin m_aeoi = wd[1]; m_phase = 0; end
          default: m_imr = wd;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input bit a, input logic [7:0] irq);
    step(a, 0, 8'h00, 0, irq);
  endtask

  task automatic configure(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    step(0, 1, 8'h11, 0, irq_in);
    step(1, 1, b, 0, irq_in);
    step(1, 1, c, 0, irq_in);
    step(1, 1, m, 0, irq_in);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  lv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(0, 0); idle(1, 0);

    cur_req = "R4";
    step(1, 1, 8'h5A, 0, 0);
    idle(1, 0);

    cur_req = "R2";
    step(0, 1, 8'h0B, 0, 0);
    configure(8'h40, 8'h04, 8'h01);
    idle(1, 0); idle(0, 0);
    cur_req = "R3";
    idle(0, 0);

    cur_req = "R5";
    idle(0, 8'h08); idle(0, 8'h08); idle(0, 8'h00); idle(0, 8'h00);

    cur_req = "R6";
    idle(0, 8'h24); idle(0, 8'h24);
    cur_req = "R7";
    step(0, 0, 8'h00, 1, 8'h24);
    idle(0, 8'h24);
    cur_req = "R10";
    step(0, 1, 8'h0B, 0, 8'h24); idle(0, 8'h24);
    cur_req = "R9";
    step(0, 1, 8'h65, 0, 8'h24); idle(0, 8'h24);
    step(0, 1, 8'h62, 0, 8'h24); idle(0, 8'h24);
    cur_req = "R7";
    step(0, 0, 8'h00, 1, 8'h24); idle(0, 8'h24);
    cur_req = "R5";
    idle(0, 8'h24); step(0, 1, 8'h0A, 0, 8'h24); idle(0, 8'h24);

    cur_req = "R12";
    step(1, 1, 8'h82, 0, 8'h00); idle(0, 8'h02); idle(0, 8'h02); idle(1, 8'h02);
    cur_req = "R11";
    step(0, 0, 8'h00, 1, 8'h02);
    step(0, 1, 8'h0B, 0, 8'h00); idle(0, 8'h00);
    idle(0, 8'h10);
    step(0, 0, 8'h00, 1, 8'h00);
    idle(0, 8'h00);
    step(0, 1, 8'h65, 0, 8'h00);

    cur_req = "R8";
    configure(8'h48, 8'h02, 8'h03);
    idle(0, 8'h01); step(0, 0, 8'h00, 1, 8'h01); idle(0, 8'h01);
    idle(0, 8'h00); idle(0, 8'h40); step(0, 0, 8'h00, 1, 8'h40); idle(0, 8'h40);

    cur_req = "R6";
    configure(8'h20, 8'h04, 8'h01);
    r = 16'hACE1;
    lv = 8'h00;
    for (int k = 0; k < 600; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      if (r[1:0] == 0) lv[r[6:4]] = ~lv[r[6:4]];
      if (r[11:9] == 0)
        step(0, 1, {5'b01100, r[14:12]}, r[15] & r[2], lv);
      else if (r[11:8] == 4'h3)
        step(1, 1, r[7:0] & 8'h1E, 0, lv);
      else if (r[11:8] == 4'h5)
        step(0, 1, r[12] ? 8'h0B : 8'h0A, 0, lv);
      else
        step(r[3], 0, 8'h00, r[5:3] == 3'b101, lv);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule